// File: doc/BRIEF.md
# Long Unsigned Divider with Overflow Flag

This block is a multicycle unsigned divider for a 16-bit CPU datapath. It divides a double-width dividend, given as a high word and a low word, by a single-width divisor. It returns a single-width quotient and remainder, one bit per clock, using a restoring shift-subtract loop. The pipeline pulses `start` with the operands and then waits for `done`.

Overflow is decided before any iteration runs. The divisor is compared with the dividend high word. If the divisor is not strictly greater than the high word, the quotient cannot fit in one word. The block then finishes on the next cycle with the overflow flag set and leaves the result registers as they were. This rule gives the correct flag for every operand pattern, including those where the top bit of both the high word and the divisor is set. A zero divisor always takes this overflow path.

Top module: `ldiv_unit`

## Requirements
- R1: After reset, `busy`, `done`, `ovf`, `quo` and `rem` are all zero.
- R2: A `start` accepted while idle with `dvsr <= dvd_hi` (unsigned) raises `done` and `ovf` on the next cycle, with `busy` never asserted.
- R3: On an overflow completion, `quo` and `rem` keep the values they held before the operation.
- R4: A `start` accepted while idle with `dvsr > dvd_hi` holds `busy` high for exactly W cycles. `done` then rises with `quo` = floor({dvd_hi,dvd_lo}/dvsr), `rem` = {dvd_hi,dvd_lo} mod dvsr, and `ovf` = 0.
- R5: `done` lasts one cycle, and `done` and `busy` are never high together.
- R6: A `start` pulse while `busy` is high is ignored. The running operation completes with the results of its original operands.
- R7: A zero divisor always completes as an overflow (`ovf` = 1), whatever the dividend.
- R8: Operands whose high word and divisor both have the top bit set are flagged correctly. Example: F0F00F0Fh / F0F0h sets `ovf`, and 70F00F0Fh / F0F0h completes with a valid result and `ovf` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a divide; honoured only when idle |
| dvd_hi | input | W | Dividend upper word |
| dvd_lo | input | W | Dividend lower word |
| dvsr | input | W | Divisor |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion pulse |
| quo | output | W | Quotient register |
| rem | output | W | Remainder register |
| ovf | output | 1 | Overflow flag of the last completed divide |

## Verification
A four-bit copy of the divider is swept over every dividend and divisor, and each result is compared against arithmetic done in the bench. That sweep lands exactly on the boundary where the divisor equals the high word. A design that used `<` instead of `<=` would return a wrapped quotient there with `ovf` clear. Directed 16-bit cases cover the top-bit patterns that a flag derived from the final subtraction would miss, and they cover zero divisors. They also check that the result registers survive an overflow: a design that wrote partial iterates would corrupt them. Start pulses during a running divide check that a busy unit does not reload its operands mid-loop.

// File: rtl/ldiv_pkg.sv
package ldiv_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ldiv_state_e;
endpackage

// File: rtl/ldiv_ovf_det.sv
module ldiv_ovf_det #(
  parameter int W = 16
) (
  input  logic [W-1:0] hi,
  input  logic [W-1:0] dvsr,
  output logic         ovf
);
  // Quotient fits in W bits only when the divisor exceeds the high word.
  always_comb ovf = (dvsr <= hi);
endmodule

// File: rtl/ldiv_step.sv
module ldiv_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dvsr,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W:0] trial;
  logic [W:0] diff;
  logic       ge;

  always_comb begin
    trial = {rem_i, quo_i[W-1]};
    ge    = (trial >= {1'b0, dvsr});
    diff  = trial - {1'b0, dvsr};
    rem_o = ge ? diff[W-1:0] : trial[W-1:0];
    quo_o = {quo_i[W-2:0], ge};
  end
endmodule

// File: rtl/ldiv_ctrl.sv
module ldiv_ctrl
  import ldiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ovf_det,
  output logic accept,
  output logic step_en,
  output logic last,
  output logic busy,
  output logic done
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

  ldiv_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    accept  = (state_q == ST_IDLE) && start;
    step_en = (state_q == ST_RUN);
    last    = step_en && (cnt_q == LAST_CNT);
    done_d  = (accept && ovf_det) || last;
    if (accept && !ovf_det) begin
      state_d = ST_RUN;
      cnt_d   = '0;
    end else if (last) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else if (step_en) begin
      cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign busy = (state_q == ST_RUN);
  assign done = done_q;
endmodule

// File: rtl/ldiv_unit.sv
module ldiv_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dvd_hi,
  input  logic [W-1:0] dvd_lo,
  input  logic [W-1:0] dvsr,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         ovf
);
  logic         ovf_det, accept, step_en, last;
  logic [W-1:0] acc_rem_q, acc_quo_q, dvsr_q;
  logic [W-1:0] acc_rem_d, acc_quo_d, dvsr_d;
  logic [W-1:0] step_rem, step_quo;
  logic [W-1:0] quo_q, rem_q, quo_d, rem_d;
  logic         ovf_q, ovf_d;

  ldiv_ovf_det #(.W(W)) u_ovf (
    .hi(dvd_hi), .dvsr(dvsr), .ovf(ovf_det)
  );

  ldiv_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .ovf_det(ovf_det),
    .accept(accept), .step_en(step_en), .last(last),
    .busy(busy), .done(done)
  );

  ldiv_step #(.W(W)) u_step (
    .rem_i(acc_rem_q), .quo_i(acc_quo_q), .dvsr(dvsr_q),
    .rem_o(step_rem), .quo_o(step_quo)
  );

  always_comb begin
    acc_rem_d = acc_rem_q;
    acc_quo_d = acc_quo_q;
    dvsr_d    = dvsr_q;
    quo_d     = quo_q;
    rem_d     = rem_q;
    ovf_d     = ovf_q;
    if (accept) begin
      if (ovf_det) begin
        ovf_d = 1'b1;
      end else begin
        acc_rem_d = dvd_hi;
        acc_quo_d = dvd_lo;
        dvsr_d    = dvsr;
      end
    end else if (step_en) begin
      acc_rem_d = step_rem;
      acc_quo_d = step_quo;
      if (last) begin
        quo_d = step_quo;
        rem_d = step_rem;
        ovf_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_rem_q <= '0;
      acc_quo_q <= '0;
      dvsr_q    <= '0;
      quo_q     <= '0;
      rem_q     <= '0;
      ovf_q     <= 1'b0;
    end else begin
      acc_rem_q <= acc_rem_d;
      acc_quo_q <= acc_quo_d;
      dvsr_q    <= dvsr_d;
      quo_q     <= quo_d;
      rem_q     <= rem_d;
      ovf_q     <= ovf_d;
    end
  end

  assign quo = quo_q;
  assign rem = rem_q;
  assign ovf = ovf_q;
endmodule

// File: rtl/ldiv_unit_chk.sv
module ldiv_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] dvd_hi,
  input logic [W-1:0] dvd_lo,
  input logic [W-1:0] dvsr,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quo,
  input logic [W-1:0] rem,
  input logic         ovf
);
  localparam int DW = 2 * W;
  logic [W-1:0] sv_hi, sv_lo, sv_d;
  logic [DW-1:0] recon;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv_hi <= '0;
      sv_lo <= '0;
      sv_d  <= '0;
    end else if (start && !busy) begin
      sv_hi <= dvd_hi;
      sv_lo <= dvd_lo;
      sv_d  <= dvsr;
    end
  end

  always_comb recon = DW'(quo) * DW'(sv_d) + DW'(rem);

  // R2
  ovf_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (dvsr <= dvd_hi)) |=> (done && ovf && !busy));
  // R3
  ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf) |-> ($stable(quo) && $stable(rem)));
  // R4
  run_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (dvsr > dvd_hi)) |=> (busy && !done));
  // R4
  result_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ovf) |-> ((recon == {sv_hi, sv_lo}) && (rem < sv_d)));
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));
  // R7
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (dvsr == '0)) |=> ovf);
endmodule

bind ldiv_unit ldiv_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dvd_hi(dvd_hi),
  .dvd_lo(dvd_lo), .dvsr(dvsr), .busy(busy), .done(done),
  .quo(quo), .rem(rem), .ovf(ovf)
);

// File: tb/ldiv_unit_test.sv
module ldiv_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int WB = 16;
  localparam int WS = 4;

  logic clk, rst_n;
  int total, bad, cyc;

  logic          b_start, b_busy, b_done, b_ovf;
  logic [WB-1:0] b_hi, b_lo, b_d, b_quo, b_rem;
  logic          s_start, s_busy, s_done, s_ovf;
  logic [WS-1:0] s_hi, s_lo, s_d, s_quo, s_rem;

  ldiv_unit #(.W(WB)) uut (
    .clk(clk), .rst_n(rst_n), .start(b_start), .dvd_hi(b_hi),
    .dvd_lo(b_lo), .dvsr(b_d), .busy(b_busy), .done(b_done),
    .quo(b_quo), .rem(b_rem), .ovf(b_ovf)
  );

  ldiv_unit #(.W(WS)) uut_small (
    .clk(clk), .rst_n(rst_n), .start(s_start), .dvd_hi(s_hi),
    .dvd_lo(s_lo), .dvsr(s_d), .busy(s_busy), .done(s_done),
    .quo(s_quo), .rem(s_rem), .ovf(s_ovf)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [WB-1:0] keep_q, keep_r;

  // Full 16-bit operation with timing, result and pulse checks.
  task automatic run_big(input logic [WB-1:0] hi, input logic [WB-1:0] lo,
                         input logic [WB-1:0] d, input bit poke);
    logic [31:0] dvd;
    bit expo;
    int n;
    bit saw_busy_done;
    dvd  = {hi, lo};
    expo = (d <= hi);
    @(negedge clk);
    b_hi = hi; b_lo = lo; b_d = d; b_start = 1'b1;
    @(negedge clk);
    b_start = 1'b0;
    n = 1;
    saw_busy_done = 1'b0;
    if (poke && !expo) begin
      // R6: disturbing start while busy
      b_start = 1'b1; b_hi = 16'h0000; b_lo = 16'h0001; b_d = 16'h0003;
    end
    while (!b_done && n < 40) begin
      if (b_busy && b_done) saw_busy_done = 1'b1;
      @(negedge clk);
      b_start = 1'b0;
      n++;
    end
    if (expo) begin
      chk(n == 1, "R2 latency", n, 1);
      chk(b_ovf == 1'b1, "R2 ovf", b_ovf, 1);
      chk(b_quo == keep_q, "R3 quo kept", b_quo, keep_q);
      chk(b_rem == keep_r, "R3 rem kept", b_rem, keep_r);
    end else begin
      chk(n == WB + 1, "R4 latency", n, WB + 1);
      chk(b_ovf == 1'b0, "R4 ovf clear", b_ovf, 0);
      chk(b_quo == WB'(dvd / d), poke ? "R6 quo" : "R4 quo", b_quo, dvd / d);
      chk(b_rem == WB'(dvd % d), poke ? "R6 rem" : "R4 rem", b_rem, dvd % d);
      keep_q = WB'(dvd / d);
      keep_r = WB'(dvd % d);
    end
    chk(!b_busy && !saw_busy_done, "R5 done without busy", b_busy, 0);
    @(negedge clk);
    chk(b_done == 1'b0, "R5 single pulse", b_done, 0);
  endtask

  initial begin
    total = 0; bad = 0; cyc = 0;
    b_start = 0; b_hi = 0; b_lo = 0; b_d = 0;
    s_start = 0; s_hi = 0; s_lo = 0; s_d = 0;
    keep_q = 0; keep_r = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({b_busy, b_done, b_ovf} == 3'b000, "R1 flags", {b_busy, b_done, b_ovf}, 0);
    chk(b_quo == 0 && b_rem == 0, "R1 results", {b_quo, b_rem}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_big(16'h0012, 16'h3456, 16'h1234, 1'b0);
    run_big(16'h7FFF, 16'hFFFF, 16'hFFFF, 1'b0);
    // R8 top-bit patterns
    run_big(16'hF0F0, 16'h0F0F, 16'hF0F0, 1'b0);
    run_big(16'h8000, 16'h000F, 16'h8000, 1'b0);
    run_big(16'h8F0F, 16'h0FFF, 16'h8F0F, 1'b0);
    run_big(16'hF000, 16'h0000, 16'hA000, 1'b0);
    run_big(16'h70F0, 16'h0F0F, 16'hF0F0, 1'b0);
    // R7 zero divisor
    run_big(16'h0000, 16'h0000, 16'h0000, 1'b0);
    run_big(16'h0000, 16'h1234, 16'h0000, 1'b0);
    chk(b_ovf == 1'b1, "R7 zero divisor", b_ovf, 1);
    // R6 start while busy
    run_big(16'h0100, 16'h0000, 16'h0300, 1'b1);
    run_big(16'h0000, 16'h0001, 16'h0001, 1'b0);

    // Exhaustive sweep of the 4-bit instance
    for (int d = 0; d < 16; d++) begin
      for (int dv = 0; dv < 256; dv++) begin
        logic [WS-1:0] pq, pr;
        int n;
        bit expo;
        pq = s_quo; pr = s_rem;
        expo = (d <= (dv >> 4));
        @(negedge clk);
        s_hi = WS'(dv >> 4); s_lo = WS'(dv); s_d = WS'(d); s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        n = 1;
        while (!s_done && n < 20) begin
          @(negedge clk);
          n++;
        end
        if (expo) begin
          chk(n == 1 && s_ovf, "R2 sweep ovf", {n[7:0], 7'd0, s_ovf}, 16'h0101);
          chk(s_quo == pq && s_rem == pr, "R3 sweep kept", {s_quo, s_rem}, {pq, pr});
        end else begin
          chk(n == WS + 1 && !s_ovf, "R4 sweep timing", {n[7:0], 7'd0, s_ovf},
              {8'(WS + 1), 8'h00});
          chk(s_quo == WS'(dv / d) && s_rem == WS'(dv % d), "R4 sweep result",
              {s_quo, s_rem}, {WS'(dv / d), WS'(dv % d)});
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule